// File: doc/BRIEF.md
# Capability Access Checker

This block judges every instruction fetch, data load and data store against a capability before the access may go ahead. A request carries an address, a byte count, an access kind and a flag that says whether a data access goes through a pointer capability. The block picks the capability that governs the request. It then tests that capability's validity tag, its permission bits and its address window, and it returns either a grant or a fault with a cause code.

Three capability sources are presented on the ports: the program-counter capability, the pointer capability of the current data access, and the default data capability. A fetch is always judged against the program-counter capability. A data access is judged against the pointer capability when it is pointer-based, and against the default data capability when it uses a plain integer address. The verdict is registered. It appears one cycle after a request is accepted, and a valid/ready pair on each side lets the consumer hold the verdict.

Top module: `cap_guard`

## Requirements
- R1: A fetch (kind 2'b00) is judged against the program-counter capability whatever the pointer flag says.
- R2: A load (kind 2'b01) or store (kind 2'b10) is judged against the pointer capability when `req_use_ptr` is 1, and against the default data capability when it is 0.
- R3: If the selected capability's tag is 0, the verdict is a fault with cause 2'd1.
- R4: Permission bits are bit 0 = load, bit 1 = store, bit 2 = execute. A fetch needs execute, a load needs load and a store needs store. A missing bit gives a fault with cause 2'd2.
- R5: The access is in bounds only if addr >= base and addr + size <= base + length. Otherwise the verdict is a fault with cause 2'd3.
- R6: Causes are ranked tag first, then permission, then bounds. A grant carries cause 2'd0 and `rsp_fault` = 0, and every fault has `rsp_grant` = 0.
- R7: The bounds sums are formed one bit wider than the address, so addr + size and base + length never wrap.
- R8: A request accepted at a clock edge (`req_valid` and `req_ready` both high) shows its verdict with `rsp_valid` = 1 right after that edge.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the verdict holds stable and `req_ready` is 0.
- R10: After reset, `rsp_valid`, `rsp_grant` and `rsp_fault` are 0 and `req_ready` is 1.
- R11: The reserved kind 2'b11 needs no permission it could ever hold. With a valid tag it always faults with cause 2'd2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 reserved |
| req_use_ptr | input | 1 | Data access goes through the pointer capability |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | SIZE_W | Number of bytes |
| pcc_tag | input | 1 | Program-counter capability tag |
| pcc_perm | input | 3 | Program-counter capability permissions |
| pcc_base | input | ADDR_W | Program-counter capability base |
| pcc_len | input | ADDR_W | Program-counter capability length |
| ptr_tag | input | 1 | Pointer capability tag |
| ptr_perm | input | 3 | Pointer capability permissions |
| ptr_base | input | ADDR_W | Pointer capability base |
| ptr_len | input | ADDR_W | Pointer capability length |
| ddc_tag | input | 1 | Default data capability tag |
| ddc_perm | input | 3 | Default data capability permissions |
| ddc_base | input | ADDR_W | Default data capability base |
| ddc_len | input | ADDR_W | Default data capability length |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access blocked |
| rsp_cause | output | 2 | 0 none, 1 tag, 2 permission, 3 bounds |

## Verification
A request often breaks several rules at once: a cleared tag, a missing permission and an address outside the window can all arrive in the same cycle. The bench sweeps every tag value, every permission pattern and both in-window and out-of-window addresses for every kind and pointer flag. It compares the reported cause with the highest-ranked failure it works out itself. The handshake has the same kind of overlap. A new request waits while a held verdict is stalled, and the cycle that releases the stall also accepts the next request. The bench checks that the held verdict does not change and that the following verdict belongs to the waiting request.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_TAG    = 2'd1,
        CAUSE_PERM   = 2'd2,
        CAUSE_BOUNDS = 2'd3
    } fault_cause_e;

    localparam int PERM_W      = 3;
    localparam int PERM_LOAD   = 0;
    localparam int PERM_STORE  = 1;
    localparam int PERM_EXEC   = 2;
    localparam int NUM_SRC     = 3;
    localparam int SRC_PCC     = 0;
    localparam int SRC_PTR     = 1;
    localparam int SRC_DDC     = 2;

    typedef struct packed {
        logic         valid;
        logic         grant;
        fault_cause_e cause;
    } verdict_t;

endpackage

// File: rtl/cap_source_mux.sv
module cap_source_mux
    import cap_guard_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  acc_kind_e                kind,
    input  logic                     use_ptr,
    input  logic [NUM_SRC-1:0]       src_tag,
    input  logic [PERM_W-1:0]        src_perm [NUM_SRC],
    input  logic [ADDR_W-1:0]        src_base [NUM_SRC],
    input  logic [ADDR_W-1:0]        src_len  [NUM_SRC],
    output logic                     sel_tag,
    output logic [PERM_W-1:0]        sel_perm,
    output logic [ADDR_W-1:0]        sel_base,
    output logic [ADDR_W-1:0]        sel_len
);
    logic [NUM_SRC-1:0] pick;

    always_comb begin
        pick = '0;
        if (kind == KIND_FETCH) begin
            pick[SRC_PCC] = 1'b1;
        end else if (use_ptr) begin
            pick[SRC_PTR] = 1'b1;
        end else begin
            pick[SRC_DDC] = 1'b1;
        end
    end

    // One-hot AND-OR selection across the sources.
    logic [NUM_SRC-1:0] tag_m;
    logic [PERM_W-1:0]  perm_m [NUM_SRC];
    logic [ADDR_W-1:0]  base_m [NUM_SRC];
    logic [ADDR_W-1:0]  len_m  [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign tag_m[s]  = pick[s] & src_tag[s];
        assign perm_m[s] = {PERM_W{pick[s]}} & src_perm[s];
        assign base_m[s] = {ADDR_W{pick[s]}} & src_base[s];
        assign len_m[s]  = {ADDR_W{pick[s]}} & src_len[s];
    end

    always_comb begin
        sel_tag  = |tag_m;
        sel_perm = '0;
        sel_base = '0;
        sel_len  = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            sel_perm = sel_perm | perm_m[s];
            sel_base = sel_base | base_m[s];
            sel_len  = sel_len  | len_m[s];
        end
    end
endmodule

// File: rtl/cap_perm_check.sv
module cap_perm_check
    import cap_guard_pkg::*;
(
    input  acc_kind_e          kind,
    input  logic [PERM_W-1:0]  perm,
    output logic               perm_ok
);
    always_comb begin
        unique case (kind)
            KIND_FETCH: perm_ok = perm[PERM_EXEC];
            KIND_LOAD:  perm_ok = perm[PERM_LOAD];
            KIND_STORE: perm_ok = perm[PERM_STORE];
            default:    perm_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_bounds_check.sv
module cap_bounds_check #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic              in_bounds
);
    localparam int WIDE_W = ADDR_W + 1;
    localparam int PAD_W  = WIDE_W - SIZE_W;

    logic [WIDE_W-1:0] first_w;
    logic [WIDE_W-1:0] end_w;
    logic [WIDE_W-1:0] limit_w;

    always_comb begin
        first_w   = {1'b0, addr};
        end_w     = first_w + {{PAD_W{1'b0}}, size};
        limit_w   = {1'b0, base} + {1'b0, len};
        in_bounds = (addr >= base) && (end_w <= limit_w);
    end
endmodule

// File: rtl/cap_guard.sv
module cap_guard
    import cap_guard_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_use_ptr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              pcc_tag,
    input  logic [2:0]        pcc_perm,
    input  logic [ADDR_W-1:0] pcc_base,
    input  logic [ADDR_W-1:0] pcc_len,
    input  logic              ptr_tag,
    input  logic [2:0]        ptr_perm,
    input  logic [ADDR_W-1:0] ptr_base,
    input  logic [ADDR_W-1:0] ptr_len,
    input  logic              ddc_tag,
    input  logic [2:0]        ddc_perm,
    input  logic [ADDR_W-1:0] ddc_base,
    input  logic [ADDR_W-1:0] ddc_len,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    acc_kind_e          kind;
    logic [NUM_SRC-1:0] src_tag;
    logic [PERM_W-1:0]  src_perm [NUM_SRC];
    logic [ADDR_W-1:0]  src_base [NUM_SRC];
    logic [ADDR_W-1:0]  src_len  [NUM_SRC];

    assign kind              = acc_kind_e'(req_kind);
    assign src_tag[SRC_PCC]  = pcc_tag;
    assign src_tag[SRC_PTR]  = ptr_tag;
    assign src_tag[SRC_DDC]  = ddc_tag;
    assign src_perm[SRC_PCC] = pcc_perm;
    assign src_perm[SRC_PTR] = ptr_perm;
    assign src_perm[SRC_DDC] = ddc_perm;
    assign src_base[SRC_PCC] = pcc_base;
    assign src_base[SRC_PTR] = ptr_base;
    assign src_base[SRC_DDC] = ddc_base;
    assign src_len[SRC_PCC]  = pcc_len;
    assign src_len[SRC_PTR]  = ptr_len;
    assign src_len[SRC_DDC]  = ddc_len;

    logic              sel_tag;
    logic [PERM_W-1:0] sel_perm;
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] sel_len;
    logic              perm_ok;
    logic              in_bounds;

    cap_source_mux #(.ADDR_W(ADDR_W)) i_mux (
        .kind     (kind),
        .use_ptr  (req_use_ptr),
        .src_tag  (src_tag),
        .src_perm (src_perm),
        .src_base (src_base),
        .src_len  (src_len),
        .sel_tag  (sel_tag),
        .sel_perm (sel_perm),
        .sel_base (sel_base),
        .sel_len  (sel_len)
    );

    cap_perm_check i_perm (
        .kind    (kind),
        .perm    (sel_perm),
        .perm_ok (perm_ok)
    );

    cap_bounds_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_bounds (
        .addr      (req_addr),
        .size      (req_size),
        .base      (sel_base),
        .len       (sel_len),
        .in_bounds (in_bounds)
    );

    verdict_t verdict_d, verdict_q;
    logic     accept;

    always_comb begin
        req_ready = !verdict_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        verdict_d = verdict_q;
        if (accept) begin
            verdict_d.valid = 1'b1;
            if (!sel_tag) begin
                verdict_d.cause = CAUSE_TAG;
            end else if (!perm_ok) begin
                verdict_d.cause = CAUSE_PERM;
            end else if (!in_bounds) begin
                verdict_d.cause = CAUSE_BOUNDS;
            end else begin
                verdict_d.cause = CAUSE_NONE;
            end
            verdict_d.grant = (verdict_d.cause == CAUSE_NONE);
        end else if (rsp_ready) begin
            verdict_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= '{valid: 1'b0, grant: 1'b0, cause: CAUSE_NONE};
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign rsp_valid = verdict_q.valid;
    assign rsp_grant = verdict_q.valid && verdict_q.grant;
    assign rsp_fault = verdict_q.valid && !verdict_q.grant;
    assign rsp_cause = verdict_q.cause;
endmodule

// File: rtl/cap_guard_chk.sv
module cap_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       req_use_ptr,
    input logic       pcc_tag,
    input logic       ptr_tag,
    input logic       ddc_tag,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic       rsp_grant,
    input logic       rsp_fault,
    input logic [1:0] rsp_cause
);
    logic chosen_tag;
    assign chosen_tag = (req_kind == 2'b00) ? pcc_tag :
                        (req_use_ptr ? ptr_tag : ddc_tag);

    // R8: verdict follows an accepted request by one edge
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R9: stalled verdict stays put
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cause) && $stable(rsp_grant));

    // R9: no new request while stalled
    a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R3: cleared tag on the chosen source gives a tag fault
    a_r3_tag_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !chosen_tag |=> rsp_fault && rsp_cause == 2'd1);

    // R6: grant and fault agree with the cause code
    a_r6_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant == (rsp_cause == 2'd0)) && (rsp_fault != rsp_grant));

    // R10: idle output side accepts
    a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready && !rsp_grant && !rsp_fault);
endmodule

bind cap_guard cap_guard_chk i_cap_guard_chk (.*);

// File: tb/test_cap_guard.sv
module test_cap_guard;
    localparam int AW = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic          req_use_ptr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic          pcc_tag = 1'b0, ptr_tag = 1'b0, ddc_tag = 1'b0;
    logic [2:0]    pcc_perm = '0, ptr_perm = '0, ddc_perm = '0;
    logic [AW-1:0] pcc_base = '0, ptr_base = '0, ddc_base = '0;
    logic [AW-1:0] pcc_len = '0, ptr_len = '0, ddc_len = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic          rsp_grant;
    logic          rsp_fault;
    logic [1:0]    rsp_cause;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cap_guard #(.ADDR_W(AW), .SIZE_W(SW)) i_cap_guard (.*);

    task automatic clear_caps();
        pcc_tag = 0; ptr_tag = 0; ddc_tag = 0;
        pcc_perm = 0; ptr_perm = 0; ddc_perm = 0;
        pcc_base = 0; ptr_base = 0; ddc_base = 0;
        pcc_len = 0; ptr_len = 0; ddc_len = 0;
    endtask

    task automatic check(string req, logic got_v, logic got_g, logic [1:0] got_c,
                         logic exp_v, logic exp_g, logic [1:0] exp_c);
        n_vec++;
        if (got_v !== exp_v || got_g !== exp_g || got_c !== exp_c) begin
            n_fail++;
            $display("FAIL %s: valid/grant/cause got %b/%b/%0d expected %b/%b/%0d",
                     req, got_v, got_g, got_c, exp_v, exp_g, exp_c);
        end
    endtask

    function automatic int expect_cause(int kind, bit tag, int perm, int addr,
                                        int size, int base, int len);
        bit need;
        if (!tag) return 1;
        case (kind)
            0: need = perm[2];
            1: need = perm[0];
            2: need = perm[1];
            default: need = 0;
        endcase
        if (!need) return 2;
        if (addr < base || addr + size > base + len) return 3;
        return 0;
    endfunction

    // Called at a negedge; returns at the next negedge with the verdict visible.
    task automatic send(int kind, bit up, int addr, int size);
        req_kind = kind[1:0]; req_use_ptr = up;
        req_addr = addr[AW-1:0]; req_size = size[SW-1:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", rsp_valid, rsp_grant, 2'(rsp_fault), 1'b0, 1'b0, 2'd0);
        if (req_ready !== 1'b1) begin
            n_fail++; $display("FAIL R10: req_ready got %b expected 1", req_ready);
        end
        n_vec++;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6 R11: source selection, tag, permission and ranking sweep
        for (int k = 0; k < 4; k++)
            for (int up = 0; up < 2; up++)
                for (int tg = 0; tg < 2; tg++)
                    for (int pm = 0; pm < 8; pm++)
                        for (int oob = 0; oob < 2; oob++) begin
                            int src;
                            int addr;
                            int ec;
                            clear_caps();
                            src = (k == 0) ? 0 : (up != 0 ? 1 : 2);
                            case (src)
                                0: begin pcc_tag = tg[0]; pcc_perm = pm[2:0]; pcc_base = 40; pcc_len = 20; end
                                1: begin ptr_tag = tg[0]; ptr_perm = pm[2:0]; ptr_base = 40; ptr_len = 20; end
                                default: begin ddc_tag = tg[0]; ddc_perm = pm[2:0]; ddc_base = 40; ddc_len = 20; end
                            endcase
                            addr = (oob != 0) ? 70 : 45;
                            ec = expect_cause(k, tg[0], pm, addr, 4, 40, 20);
                            send(k, up[0], addr, 4);
                            check(k == 3 ? "R11" : (src == 0 ? "R1/R6" : "R2/R3/R4/R6"),
                                  rsp_valid, rsp_grant, rsp_cause,
                                  1'b1, ec == 0, ec[1:0]);
                            if (rsp_fault !== (ec != 0)) begin
                                n_fail++;
                                $display("FAIL R6: fault got %b expected %b", rsp_fault, ec != 0);
                            end
                        end

        // R5 R7: bounds sweep through the default data capability, including sums past 2^AW
        clear_caps();
        ddc_tag = 1; ddc_perm = 3'b111;
        for (int bi = 0; bi < 4; bi++)
            for (int li = 0; li < 4; li++)
                for (int a = 0; a < 256; a += 3)
                    for (int si = 0; si < 4; si++) begin
                        int bases [4] = '{0, 100, 200, 250};
                        int lens  [4] = '{0, 5, 40, 255};
                        int sizes [4] = '{0, 1, 4, 7};
                        int ec;
                        ddc_base = bases[bi][AW-1:0];
                        ddc_len  = lens[li][AW-1:0];
                        ec = expect_cause(1, 1'b1, 7, a, sizes[si], bases[bi], lens[li]);
                        send(1, 1'b0, a, sizes[si]);
                        check((bases[bi] + lens[li] > 255 || a + sizes[si] > 255) ? "R7" : "R5",
                              rsp_valid, rsp_grant, rsp_cause, 1'b1, ec == 0, ec[1:0]);
                    end

        // R8 R9: stall with a waiting request, then release
        clear_caps();
        ptr_tag = 1; ptr_perm = 3'b010; ptr_base = 10; ptr_len = 50;
        rsp_ready = 1'b0;
        req_kind = 2'b10; req_use_ptr = 1; req_addr = 12; req_size = 2; req_valid = 1'b1;
        @(negedge clk);
        check("R8", rsp_valid, rsp_grant, rsp_cause, 1'b1, 1'b1, 2'd0);
        req_kind = 2'b01; req_addr = 12;   // load without load permission: waits
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9", rsp_valid, rsp_grant, rsp_cause, 1'b1, 1'b1, 2'd0);
            check("R9", req_ready, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8/R9", rsp_valid, rsp_grant, rsp_cause, 1'b1, 1'b0, 2'd2);
        @(negedge clk);
        check("R8", rsp_valid, rsp_grant, rsp_cause, 1'b0, 1'b0, 2'd2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule